// File: doc/BRIEF.md
# AES-128 Round Key Sequencer

This block turns a 128-bit cipher key into the eleven 128-bit round keys that a ten-round AES-128 datapath consumes, and hands them out one per clock cycle. A single start pulse captures the key and a direction flag. The block first expands the whole schedule into an internal bank of eleven key registers. It then streams that bank out, each key tagged with its round number and qualified by a valid strobe. A one-cycle completion pulse follows the last key.

The same forward expansion serves both directions. For encryption the bank is read from round 0 up to round 10. For decryption it is read from round 10 down to round 0, so an inverse-cipher datapath receives the last round key first. While a job is in progress the block is busy, and further start requests are dropped.

Top module: `kx_keysched`

## Requirements
- R1: While reset is asserted and after its release, before any start, key_valid and done are 0, round_idx is 0 and round_key is all zeros.
- R2: The key output with round_idx 0 equals the key captured at the accepted start, unchanged.
- R3: Keys are 128 bits with word 0 in bits [127:96] and word 3 in bits [31:0], and the most significant byte first within each word. Key n+1 is built as follows. Its word 0 is word 0 of key n XOR the S-box applied bytewise to word 3 of key n rotated left by one byte, XOR the round constant. Each later word j is word j of key n XOR the new word j-1.
- R4: The round constant for building key n (n = 1..10) has the value x^(n-1) in GF(2^8) modulo x^8+x^4+x^3+x+1 (01, 02, 04, 08, 10, 20, 40, 80, 1B, 36). It sits in the top byte of the word, with the lower three bytes zero.
- R5: With decrypt low at the accepted start, the keys come out on 11 consecutive cycles with round_idx 0, 1, ..., 10.
- R6: With decrypt high at the accepted start, the keys come out on 11 consecutive cycles with round_idx 10, 9, ..., 0, each carrying the key of that round.
- R7: The first key is visible 11 clock edges after the edge that accepts start. key_valid is high for exactly 11 consecutive cycles per job and is low during expansion.
- R8: done is high for exactly one cycle, the cycle right after the last key. key_valid is low in that cycle.
- R9: A start seen while a job is in progress, including the done-generation cycle, is ignored. key and decrypt are sampled only at an accepted start, so later changes to them have no effect on the running job.
- R10: A start asserted in the cycle where done is high is accepted, so jobs can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new schedule; honoured only when idle |
| decrypt | input | 1 | 1 = stream keys last round first; sampled with start |
| key | input | 128 | Cipher key; sampled with start |
| round_key | output | 128 | Current round key |
| round_idx | output | 4 | Round number of round_key, 0..10 |
| key_valid | output | 1 | round_key and round_idx are valid this cycle |
| done | output | 1 | One-cycle pulse after the last key |

## Verification
Counting from the clock edge that accepts start, expansion takes edges 1 to 10 with key_valid low. Key k of the stream (k = 0..10) appears after edge 11+k, and done rises after edge 22 and clears after edge 23. The bench raises start half a period before the accepting edge. It then samples every output at the falling edge following each of those 22 edges and compares against a schedule it computes itself, with its own S-box derived by exhaustive inversion search and its own round constant list. The bench also asserts stray starts with a different key and direction during expansion and during streaming, then checks that the whole sequence stays unchanged at every cycle. The next job starts during the done cycle, so that back-to-back acceptance is checked on the same cycle grid.

// File: rtl/kx_pkg.sv
package kx_pkg;

  localparam int KEY_BITS   = 128;
  localparam int WORD_BITS  = 32;
  localparam int BYTE_BITS  = 8;
  localparam int NUM_WORDS  = KEY_BITS / WORD_BITS;
  localparam int WORD_BYTES = WORD_BITS / BYTE_BITS;
  localparam int NUM_ROUNDS = 10;
  localparam int NUM_KEYS   = NUM_ROUNDS + 1;
  localparam int IDX_BITS   = $clog2(NUM_KEYS);

  typedef logic [KEY_BITS-1:0]  key_t;
  typedef logic [WORD_BITS-1:0] word_t;
  typedef logic [BYTE_BITS-1:0] byte_t;
  typedef logic [IDX_BITS-1:0]  idx_t;

  localparam idx_t LAST_IDX  = idx_t'(NUM_ROUNDS);
  localparam idx_t FIRST_IDX = idx_t'(0);

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_EXPAND = 2'd1,
    PH_STREAM = 2'd2,
    PH_FINISH = 2'd3
  } phase_t;

  // Multiply by x modulo the field polynomial.
  function automatic byte_t gf_dbl(input byte_t a);
    gf_dbl = {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
  endfunction

  // Shift-and-add field multiply.
  function automatic byte_t gf_mul(input byte_t a, input byte_t b);
    byte_t acc;
    byte_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < BYTE_BITS; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_dbl(sh);
    end
    gf_mul = acc;
  endfunction

  // Inverse as a^254; maps zero to zero.
  function automatic byte_t gf_inv(input byte_t a);
    localparam byte_t EXPN = 8'd254;
    byte_t res;
    byte_t base;
    res  = 8'h01;
    base = a;
    for (int i = 0; i < BYTE_BITS; i++) begin
      if (EXPN[i]) res = gf_mul(res, base);
      base = gf_mul(base, base);
    end
    gf_inv = res;
  endfunction

  function automatic byte_t rotl8(input byte_t b, input int n);
    rotl8 = byte_t'((b << n) | (b >> (BYTE_BITS - n)));
  endfunction

  // Forward substitution byte: inverse then affine map.
  function automatic byte_t sub_byte(input byte_t a);
    byte_t v;
    v = gf_inv(a);
    sub_byte = v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
  endfunction

  // Round constant byte for building key number rnd (1..NUM_ROUNDS).
  function automatic byte_t rcon_byte(input idx_t rnd);
    byte_t c;
    c = 8'h01;
    for (int i = 1; i < NUM_ROUNDS; i++) begin
      if (idx_t'(i) < rnd) c = gf_dbl(c);
    end
    rcon_byte = c;
  endfunction

  function automatic word_t rot_word(input word_t w);
    rot_word = {w[WORD_BITS-BYTE_BITS-1:0], w[WORD_BITS-1 -: BYTE_BITS]};
  endfunction

endpackage

// File: rtl/kx_subword.sv
module kx_subword
  import kx_pkg::*;
(
  input  word_t word_in,
  output word_t word_out
);

  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
    assign word_out[b*BYTE_BITS +: BYTE_BITS] = sub_byte(word_in[b*BYTE_BITS +: BYTE_BITS]);
  end

endmodule

// File: rtl/kx_step.sv
module kx_step
  import kx_pkg::*;
(
  input  key_t prev_key,
  input  idx_t rnd,
  output key_t next_key
);

  word_t prev_w [NUM_WORDS];
  word_t new_w  [NUM_WORDS];
  word_t rotated;
  word_t subbed;
  word_t rcon_w;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_split
    assign prev_w[w] = prev_key[KEY_BITS-1-w*WORD_BITS -: WORD_BITS];
  end

  assign rotated = rot_word(prev_w[NUM_WORDS-1]);
  assign rcon_w  = {rcon_byte(rnd), {(WORD_BITS-BYTE_BITS){1'b0}}};

  kx_subword u_sub (
    .word_in  (rotated),
    .word_out (subbed)
  );

  assign new_w[0] = prev_w[0] ^ subbed ^ rcon_w;

  for (genvar w = 1; w < NUM_WORDS; w++) begin : g_chain
    assign new_w[w] = prev_w[w] ^ new_w[w-1];
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_join
    assign next_key[KEY_BITS-1-w*WORD_BITS -: WORD_BITS] = new_w[w];
  end

endmodule

// File: rtl/kx_bank.sv
module kx_bank
  import kx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  idx_t wr_idx,
  input  key_t wr_data,
  input  idx_t rd_idx,
  output key_t rd_data,
  output key_t slot0
);

  key_t mem [NUM_KEYS];

  for (genvar g = 0; g < NUM_KEYS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[g] <= '0;
      end else if (wr_en && (wr_idx == idx_t'(g))) begin
        mem[g] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_KEYS; i++) begin
      if (rd_idx == idx_t'(i)) rd_data = mem[i];
    end
  end

  assign slot0 = mem[0];

endmodule

// File: rtl/kx_ctrl.sv
module kx_ctrl
  import kx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic decrypt,
  output logic busy,
  output logic mode_q,
  output logic accept,
  output logic gen_step,
  output logic stream_step,
  output idx_t step_idx,
  output idx_t rd_idx,
  output logic key_valid,
  output logic done
);

  phase_t phase;
  idx_t   cnt;
  logic   at_last;

  assign busy        = (phase != PH_IDLE);
  assign accept      = (phase == PH_IDLE) && start;
  assign gen_step    = (phase == PH_EXPAND);
  assign stream_step = (phase == PH_STREAM);
  assign at_last     = (cnt == LAST_IDX);
  assign step_idx    = cnt;
  assign rd_idx      = mode_q ? (LAST_IDX - cnt) : cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= FIRST_IDX;
      mode_q <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase  <= PH_EXPAND;
            cnt    <= idx_t'(1);
            mode_q <= decrypt;
          end
        end
        PH_EXPAND: begin
          if (at_last) begin
            phase <= PH_STREAM;
            cnt   <= FIRST_IDX;
          end else begin
            cnt <= cnt + idx_t'(1);
          end
        end
        PH_STREAM: begin
          if (at_last) begin
            phase <= PH_FINISH;
            cnt   <= FIRST_IDX;
          end else begin
            cnt <= cnt + idx_t'(1);
          end
        end
        default: begin
          phase <= PH_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_valid <= 1'b0;
      done      <= 1'b0;
    end else begin
      key_valid <= stream_step;
      done      <= (phase == PH_FINISH);
    end
  end

endmodule

// File: rtl/kx_keysched.sv
module kx_keysched
  import kx_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         decrypt,
  input  logic [127:0] key,
  output logic [127:0] round_key,
  output logic [3:0]   round_idx,
  output logic         key_valid,
  output logic         done
);

  logic busy;
  logic mode_q;
  logic accept;
  logic gen_step;
  logic stream_step;
  idx_t step_idx;
  idx_t rd_idx;
  key_t work_q;
  key_t next_key;
  key_t rd_data;
  key_t base_key;
  logic bank_we;
  idx_t bank_widx;
  key_t bank_wdata;

  kx_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .decrypt     (decrypt),
    .busy        (busy),
    .mode_q      (mode_q),
    .accept      (accept),
    .gen_step    (gen_step),
    .stream_step (stream_step),
    .step_idx    (step_idx),
    .rd_idx      (rd_idx),
    .key_valid   (key_valid),
    .done        (done)
  );

  kx_step u_step (
    .prev_key (work_q),
    .rnd      (step_idx),
    .next_key (next_key)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
    end else if (accept) begin
      work_q <= key;
    end else if (gen_step) begin
      work_q <= next_key;
    end
  end

  assign bank_we    = accept || gen_step;
  assign bank_widx  = accept ? FIRST_IDX : step_idx;
  assign bank_wdata = accept ? key : next_key;

  kx_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bank_we),
    .wr_idx  (bank_widx),
    .wr_data (bank_wdata),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .slot0   (base_key)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      round_key <= '0;
      round_idx <= '0;
    end else if (stream_step) begin
      round_key <= rd_data;
      round_idx <= rd_idx;
    end
  end

endmodule

// File: rtl/kx_keysched_chk.sv
module kx_keysched_chk
  import kx_pkg::*;
(
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         mode_q,
  input logic [127:0] base_key,
  input logic [127:0] round_key,
  input logic [3:0]   round_idx,
  input logic         key_valid,
  input logic         done
);

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> round_idx <= LAST_IDX); // R5

  AST_FWD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid && !mode_q && round_idx != FIRST_IDX |-> $past(key_valid) && ($past(round_idx) == round_idx - 4'd1)); // R5

  AST_REV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid && mode_q && round_idx != LAST_IDX |-> $past(key_valid) && ($past(round_idx) == round_idx + 4'd1)); // R6

  AST_STREAM_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_valid) |-> round_idx == (mode_q ? LAST_IDX : FIRST_IDX)); // R6

  AST_FIRST_KEY_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid && round_idx == FIRST_IDX |-> round_key == base_key); // R2

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !key_valid); // R8

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(key_valid) && ($past(round_idx) == (mode_q ? FIRST_IDX : LAST_IDX))); // R8

  AST_BUSY_START_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy |=> $stable(mode_q) && $stable(base_key)); // R9

endmodule

bind kx_keysched kx_keysched_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .mode_q    (mode_q),
  .base_key  (base_key),
  .round_key (round_key),
  .round_idx (round_idx),
  .key_valid (key_valid),
  .done      (done)
);

// File: tb/tb_kx_keysched.sv
`timescale 1ns/1ps
module tb_kx_keysched;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         decrypt = 1'b0;
  logic [127:0] key = '0;
  logic [127:0] round_key;
  logic [3:0]   round_idx;
  logic         key_valid;
  logic         done;

  int n_checks = 0;
  int n_errors = 0;

  logic [7:0]   sbox_t [256];
  logic [127:0] expk   [11];

  always #2.5 clk = ~clk;

  kx_keysched dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .decrypt   (decrypt),
    .key       (key),
    .round_key (round_key),
    .round_idx (round_idx),
    .key_valid (key_valid),
    .done      (done)
  );

  // Polynomial product then long division by 0x11B.
  function automatic logic [7:0] pmul(input logic [7:0] a, input logic [7:0] b);
    logic [14:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (15'(a) << i);
    for (int j = 14; j >= 8; j--) if (p[j]) p = p ^ (15'h11B << (j - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] affine(input logic [7:0] x);
    logic [7:0] o;
    for (int i = 0; i < 8; i++)
      o[i] = x[i] ^ x[(i+4)%8] ^ x[(i+5)%8] ^ x[(i+6)%8] ^ x[(i+7)%8];
    return o ^ 8'h63;
  endfunction

  task automatic build_sbox();
    logic [7:0] inv;
    for (int a = 0; a < 256; a++) begin
      inv = 8'h00;
      for (int b = 1; b < 256; b++)
        if (a != 0 && pmul(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
      sbox_t[a] = affine(inv);
    end
  endtask

  // R4 constants listed directly.
  function automatic logic [7:0] rc(input int n);
    case (n)
      1: return 8'h01; 2: return 8'h02; 3: return 8'h04; 4: return 8'h08;
      5: return 8'h10; 6: return 8'h20; 7: return 8'h40; 8: return 8'h80;
      9: return 8'h1B; default: return 8'h36;
    endcase
  endfunction

  task automatic expand(input logic [127:0] k);
    logic [31:0] w [44];
    logic [31:0] t;
    for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {sbox_t[t[23:16]], sbox_t[t[15:8]], sbox_t[t[7:0]], sbox_t[t[31:24]]};
        t = t ^ {rc(i/4), 24'h0};
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) expk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // One job; poke = issue stray starts during expansion and streaming.
  task automatic run_job(input logic [127:0] k, input logic dec, input logic poke);
    int exp_idx;
    expand(k);
    start = 1'b1; key = k; decrypt = dec;
    @(posedge clk); @(negedge clk);
    start = 1'b0; key = ~k; decrypt = ~dec;   // R9: later changes must not matter
    for (int c = 1; c <= 22; c++) begin
      @(posedge clk); @(negedge clk);
      if (c <= 10) begin
        chk("R7 valid low while expanding", 128'(key_valid), 128'(0));
        chk("R8 done low while expanding", 128'(done), 128'(0));
      end else if (c <= 21) begin
        exp_idx = dec ? (21 - c) : (c - 11);
        chk("R7 valid during stream", 128'(key_valid), 128'(1));
        chk(dec ? "R6 idx order" : "R5 idx order", 128'(round_idx), 128'(exp_idx));
        if (exp_idx == 0)      chk("R2 key0", round_key, expk[0]);
        else if (exp_idx >= 9) chk("R4 key", round_key, expk[exp_idx]);
        else                   chk("R3 key", round_key, expk[exp_idx]);
        chk("R8 done low during stream", 128'(done), 128'(0));
      end else begin
        chk("R8 done pulse", 128'(done), 128'(1));
        chk("R8 valid low at done", 128'(key_valid), 128'(0));
      end
      if (poke && (c == 4 || c == 15)) begin
        start = 1'b1; key = k ^ 128'h5A5A; decrypt = ~dec;   // R9 stray start
      end else begin
        start = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    build_sbox();
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 128'(key_valid), 128'(0));
    chk("R1 done in reset", 128'(done), 128'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idx after reset", 128'(round_idx), 128'(0));
    chk("R1 key after reset", round_key, 128'(0));
    chk("R1 valid after reset", 128'(key_valid), 128'(0));

    expand(128'h2b7e151628aed2a6abf7158809cf4f3c);
    chk("R4 known last key", expk[10], 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);

    run_job(128'h2b7e151628aed2a6abf7158809cf4f3c, 1'b0, 1'b0);
    // R10: next job starts in the done cycle
    run_job(128'h2b7e151628aed2a6abf7158809cf4f3c, 1'b1, 1'b1);
    run_job(128'h0, 1'b0, 1'b1);
    run_job(128'h0, 1'b1, 1'b0);
    run_job({128{1'b1}}, 1'b1, 1'b0);
    run_job(128'h000102030405060708090a0b0c0d0e0f, 1'b0, 1'b0);
    run_job(128'hdeadbeef0123456789abcdeffedcba98, 1'b1, 1'b1);
    @(posedge clk); @(negedge clk);
    chk("R8 done cleared", 128'(done), 128'(0));
    chk("R7 valid stays low when idle", 128'(key_valid), 128'(0));

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule